// File: doc/BRIEF.md
# Instruction-Decoded Rotate-Right Unit

This block takes one instruction word per cycle, works out whether it is one of five rotate-right operations, and produces the rotated value one clock later. Two operations work on a 32-bit word. Three work on the full 64-bit operand. The rotate distance comes from one of three places: the instruction's shift-amount field, that field plus 32, or the low bits of a second register value.

Each issued word is sorted into one of three outcomes, held in a small output state register. `S_IDLE` means nothing was issued. `S_DONE` means a legal rotate was issued and its result is on `res_data`. `S_FAULT` means the issued word was not a legal rotate. The transition is taken on every clock:
- with no issue, go to `S_IDLE`;
- with a legal issue, go to `S_DONE`;
- with an illegal issue, go to `S_FAULT`.

Reset puts the register in `S_IDLE`. Register-file reads and writes are the caller's job, and so is sign extension of 32-bit results.

Instruction fields used by the decoder:
- opcode: bits [31:26]
- first source field: bits [25:21]
- shift-amount field: bits [10:6]
- function code: bits [5:0]

Top module: `instr_rotator`

## Requirements
- R1: While reset is asserted and until the first issue after it, `res_valid`, `res_illegal` and `res_data` are all zero.
- R2: Narrow rotate by immediate: opcode 000000, bits [25:21] = 00001, function 000010. The low 32 result bits are `src_t[31:0]` rotated right by bits [10:6].
- R3: Narrow rotate by register: opcode 000000, bits [10:6] = 00001, function 000110. The distance is `src_s[4:0]`, and the upper bits of `src_s` have no effect.
- R4: Wide rotate by immediate: opcode 000000, bits [25:21] = 00001, function 111010. The result is the 64-bit `src_t` rotated right by bits [10:6].
- R5: Wide rotate by immediate plus 32: opcode 000000, bits [25:21] = 00001, function 111110. The result is `src_t` rotated right by bits [10:6] + 32.
- R6: Wide rotate by register: opcode 000000, bits [10:6] = 00001, function 010110. The distance is `src_s[5:0]`, and `src_s[63:6]` has no effect.
- R7: A narrow rotate uses only `src_t[31:0]`, and drives `res_data[63:32]` to zero.
- R8: A distance of zero returns the operand unchanged. For the narrow forms this is `src_t[31:0]` with the upper half zero.
- R9: If the opcode and function code match a rotate but the fixed field (bits [25:21] for immediate forms, bits [10:6] for register forms) is not 00001, the unit sets `res_illegal`, clears `res_valid`, and leaves `res_data` unchanged.
- R10: An issued word with a non-zero opcode, or with a function code that is not one of the five, sets `res_illegal` and clears `res_valid`.
- R11: Outputs follow an issue by exactly one clock. In a cycle with no issue, the next cycle shows `res_valid` = 0 and `res_illegal` = 0, and `res_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| src_t | input | 64 | Operand to be rotated |
| src_s | input | 64 | Register supplying the rotate distance for the variable forms |
| res_data | output | 64 | Rotated result, registered |
| res_valid | output | 1 | A legal rotate was issued in the previous cycle |
| res_illegal | output | 1 | An illegal word was issued in the previous cycle |

## Verification
The hardest cases are the ones where the fixed field is wrong but everything else points to a valid rotate. Another hard case is a distance that would be legal if the decoder ignored the extra bit of `src_s`: bit 5 for the narrow form, bit 6 for the wide form.

The stimulus reaches these by taking a legal encoding and changing one field value. It then checks that `res_data` still holds the value from the previous legal result. It also drives `src_s` values whose discarded high bits are set, and narrow operands whose upper half is full of ones, so that any leak of those bits shows up in the result.

// File: rtl/rot_pkg.sv
package rot_pkg;
    localparam int XLEN  = 64;
    localparam int AMT_W = $clog2(XLEN);

    localparam logic [5:0] OPC_SPECIAL  = 6'b000000;
    localparam logic [4:0] FIXED_MARK   = 5'b00001;
    localparam logic [5:0] FN_N_IMM     = 6'b000010;
    localparam logic [5:0] FN_N_REG     = 6'b000110;
    localparam logic [5:0] FN_W_IMM     = 6'b111010;
    localparam logic [5:0] FN_W_IMM32   = 6'b111110;
    localparam logic [5:0] FN_W_REG     = 6'b010110;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_N_IMM,
        OP_N_REG,
        OP_W_IMM,
        OP_W_IMM32,
        OP_W_REG
    } rot_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DONE,
        S_FAULT
    } out_state_e;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
    import rot_pkg::*;
(
    input  logic [31:0]      instr,
    input  logic [AMT_W-1:0] reg_amt,
    output rot_op_e          op,
    output logic             legal,
    output logic             narrow,
    output logic [AMT_W-1:0] amt
);
    logic [5:0] opc;
    logic [4:0] f_src;
    logic [4:0] f_sa;
    logic [5:0] fn;

    assign opc   = instr[31:26];
    assign f_src = instr[25:21];
    assign f_sa  = instr[10:6];
    assign fn    = instr[5:0];

    always_comb begin
        op = OP_NONE;
        if (opc == OPC_SPECIAL) begin
            unique case (fn)
                FN_N_IMM:   op = (f_src == FIXED_MARK) ? OP_N_IMM   : OP_NONE;
                FN_W_IMM:   op = (f_src == FIXED_MARK) ? OP_W_IMM   : OP_NONE;
                FN_W_IMM32: op = (f_src == FIXED_MARK) ? OP_W_IMM32 : OP_NONE;
                FN_N_REG:   op = (f_sa  == FIXED_MARK) ? OP_N_REG   : OP_NONE;
                FN_W_REG:   op = (f_sa  == FIXED_MARK) ? OP_W_REG   : OP_NONE;
                default:    op = OP_NONE;
            endcase
        end
    end

    always_comb begin
        amt    = '0;
        narrow = 1'b0;
        unique case (op)
            OP_N_IMM:   begin amt = {1'b0, f_sa};              narrow = 1'b1; end
            OP_N_REG:   begin amt = {1'b0, reg_amt[AMT_W-2:0]}; narrow = 1'b1; end
            OP_W_IMM:   amt = {1'b0, f_sa};
            OP_W_IMM32: amt = {1'b1, f_sa};
            OP_W_REG:   amt = reg_amt;
            default:    amt = '0;
        endcase
    end

    assign legal = (op != OP_NONE);

    always_comb begin
        if (legal) begin
            AST_LEGAL_SPECIAL: assert (opc == OPC_SPECIAL); // R10
        end
        if (narrow) begin
            AST_NARROW_AMT: assert (amt[AMT_W-1] == 1'b0); // R3
        end
    end
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
    parameter int W = 64
) (
    input  logic [W-1:0]         data,
    input  logic [$clog2(W)-1:0] amt,
    input  logic                 narrow,
    output logic [W-1:0]         result
);
    localparam int SW = $clog2(W);
    localparam int HW = W / 2;

    logic [W-1:0] stage [SW+1];

    // A narrow word is doubled so that a full-width rotate leaves the
    // narrow rotate in the low half.
    assign stage[0] = narrow ? {data[HW-1:0], data[HW-1:0]} : data;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stage[k+1] = amt[k] ? {stage[k][D-1:0], stage[k][W-1:D]} : stage[k];
    end

    assign result = narrow ? {{HW{1'b0}}, stage[SW][HW-1:0]} : stage[SW];

    always_comb begin
        if (amt == '0 && !narrow) begin
            AST_ZERO_IDENT: assert (result == data); // R8
        end
    end
endmodule

// File: rtl/instr_rotator.sv
module instr_rotator
    import rot_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src_t,
    input  logic [XLEN-1:0] src_s,
    output logic [XLEN-1:0] res_data,
    output logic            res_valid,
    output logic            res_illegal
);
    rot_op_e          dec_op;
    logic             dec_legal;
    logic             dec_narrow;
    logic [AMT_W-1:0] dec_amt;
    logic [XLEN-1:0]  rot_out;
    out_state_e       state_q, state_d;
    logic [XLEN-1:0]  data_q;

    rot_decode u_dec (
        .instr   (instr),
        .reg_amt (src_s[AMT_W-1:0]),
        .op      (dec_op),
        .legal   (dec_legal),
        .narrow  (dec_narrow),
        .amt     (dec_amt)
    );

    rot_barrel #(.W(XLEN)) u_rot (
        .data   (src_t),
        .amt    (dec_amt),
        .narrow (dec_narrow),
        .result (rot_out)
    );

    always_comb begin
        unique case ({issue_valid, dec_legal})
            2'b11:   state_d = S_DONE;
            2'b10:   state_d = S_FAULT;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == S_DONE) begin
                data_q <= rot_out;
            end
        end
    end

    always_comb begin
        res_valid   = 1'b0;
        res_illegal = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_DONE:  res_valid   = 1'b1;
            S_FAULT: res_illegal = 1'b1;
            default: ;
        endcase
    end

    assign res_data = data_q;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_illegal)); // R9

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || res_illegal) |-> $past(issue_valid)); // R11

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data)); // R11

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && dec_legal && dec_narrow) |=> (res_data[XLEN-1:XLEN/2] == '0)); // R7

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && dec_legal && !dec_narrow && dec_amt == '0) |=> (res_data == $past(src_t))); // R8
endmodule

// File: tb/instr_rotator_test.sv
module instr_rotator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_t = '0;
    logic [63:0] src_s = '0;
    logic [63:0] res_data;
    logic        res_valid;
    logic        res_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [63:0] m_data = '0;
    logic        m_valid = 1'b0;
    logic        m_ill = 1'b0;

    always #10 clk = ~clk;

    instr_rotator uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .src_t(src_t), .src_s(src_s), .res_data(res_data),
        .res_valid(res_valid), .res_illegal(res_illegal)
    );

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] a,
                                       input logic [4:0] sa, input logic [5:0] fn);
        return {opc, a, 5'd3, 5'd7, sa, fn};
    endfunction

    function automatic logic [63:0] rotr(input logic [63:0] x, input int s, input int w);
        logic [63:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = x[(i + s) % w];
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        check({tag, " data"},  res_data, m_data);
        check({tag, " valid"}, {63'b0, res_valid}, {63'b0, m_valid});
        check({tag, " ill"},   {63'b0, res_illegal}, {63'b0, m_ill});
    endtask

    // Behavioural reference: decide the outcome from the field values.
    task automatic step(input string tag, input logic v, input logic [31:0] ins,
                        input logic [63:0] t, input logic [63:0] s);
        int amt = 0;
        int w = 64;
        bit ok = 0;
        issue_valid = v; instr = ins; src_t = t; src_s = s;
        if (ins[31:26] == 6'd0) begin
            if (ins[5:0] == 6'b000010 && ins[25:21] == 5'd1) begin ok = 1; w = 32; amt = int'(ins[10:6]); end
            if (ins[5:0] == 6'b000110 && ins[10:6]  == 5'd1) begin ok = 1; w = 32; amt = int'(s[4:0]); end
            if (ins[5:0] == 6'b111010 && ins[25:21] == 5'd1) begin ok = 1; amt = int'(ins[10:6]); end
            if (ins[5:0] == 6'b111110 && ins[25:21] == 5'd1) begin ok = 1; amt = int'(ins[10:6]) + 32; end
            if (ins[5:0] == 6'b010110 && ins[10:6]  == 5'd1) begin ok = 1; amt = int'(s[5:0]); end
        end
        @(negedge clk);
        m_valid = v && ok;
        m_ill   = v && !ok;
        if (v && ok) m_data = rotr(t, amt, w);
        compare(tag);
    endtask

    initial begin
        logic [63:0] a = 64'hAAAA_BBBB_1234_5678;
        logic [63:0] b = 64'h0123_4567_89AB_CDEF;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        step("R1 idle", 0, '0, '0, '0);
        step("R2", 1, mk(0, 1, 8, 6'b000010), a, '0);
        step("R7", 1, mk(0, 1, 31, 6'b000010), 64'hFFFF_FFFF_8000_0001, '0);
        step("R8 narrow", 1, mk(0, 1, 0, 6'b000010), a, '0);
        step("R3", 1, mk(0, 5'd9, 1, 6'b000110), b, 64'hFFFF_FFFF_FFFF_FFE3);
        step("R3 bit5", 1, mk(0, 5'd9, 1, 6'b000110), b, 64'h0000_0000_0000_0020);
        step("R4", 1, mk(0, 1, 4, 6'b111010), b, '0);
        step("R8 wide", 1, mk(0, 1, 0, 6'b111010), b, '0);
        step("R5 swap", 1, mk(0, 1, 0, 6'b111110), b, '0);
        step("R5 max", 1, mk(0, 1, 31, 6'b111110), b, '0);
        step("R6", 1, mk(0, 5'd2, 1, 6'b010110), a, 64'h0000_0000_0000_007F);
        step("R6 mid", 1, mk(0, 5'd2, 1, 6'b010110), b, 64'hFF00_0000_0000_0011);
        step("R11 idle", 0, mk(0, 1, 4, 6'b111010), a, '0);
        step("R9 imm", 1, mk(0, 5'd2, 4, 6'b000010), a, '0);
        step("R9 reg", 1, mk(0, 5'd1, 0, 6'b000110), a, 64'd5);
        step("R9 w32", 1, mk(0, 5'd0, 4, 6'b111110), a, '0);
        step("R9 wreg", 1, mk(0, 5'd1, 3, 6'b010110), a, 64'd5);
        step("R10 opc", 1, mk(6'd1, 1, 4, 6'b000010), a, '0);
        step("R10 fn", 1, mk(0, 1, 4, 6'b000000), a, '0);
        step("R11 back", 1, mk(0, 1, 12, 6'b111010), a, '0);
        step("R11 back2", 1, mk(0, 1, 1, 6'b000010), b, '0);
        step("R11 rest", 0, '0, b, b);
        for (int i = 0; i < 64; i++) begin
            step("R6 sweep", 1, mk(0, 5'd4, 1, 6'b010110), b ^ (64'(i) << 7), 64'(i));
            step("R2 sweep", 1, mk(0, 1, 5'(i), 6'b000010), a + 64'(i), '0);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got running expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule